// File: doc/BRIEF.md
# Critical-Word-First Line Refill Sequencer

This block sits between a cache miss handler and a memory port that delivers one word per beat. When a miss arrives it fetches a whole cache line, one word at a time, and writes every returned word into a line buffer at that word's own index. The processor waits on the miss. It is released as soon as the word it asked for has arrived, while the rest of the line keeps filling.

Two fetch orders are supported and chosen per miss. In critical-word-first order the missed word is fetched first and the others follow in wrap-around order. In early-restart order the words are fetched from index 0 upward and the release happens when the requested index comes by. The handler sees one restart pulse carrying the requested word. It later sees a line-done pulse, and at that same point the line is marked valid. While a refill runs the unit refuses further misses.

The controller is a four-state machine. IDLE accepts a miss (transition *accept*) and moves to ISSUE. ISSUE holds a memory request until it is taken (transition *granted*) and moves to WAIT. WAIT takes one response (transition *beat_in*) and returns to ISSUE. After the final beat it moves instead to FINISH (transition *last_beat_in*). FINISH lasts one cycle and returns to IDLE (transition *retire*).

Top module: `line_refill_seq`

## Requirements
- R1: After reset, busy, mem_req_valid, restart_pulse, line_done and line_valid are 0, and miss_ready is 1.
- R2: With mode_early = 0, beat k of a refill requests word index (c + k) mod WORDS, where c is the missed index. The request address is {line address, word index}. For a 4-word line with c = 2 the order is 2, 3, 0, 1.
- R3: With mode_early = 1, beat k requests word index k, so the order is 0, 1, ..., WORDS-1 whatever the missed index.
- R4: Each returned word is stored at its own index. After the refill, line_data bits [i*WORD_W +: WORD_W] hold the word returned for index i.
- R5: Each refill raises restart_pulse for exactly one cycle. That cycle is the one after the response for the missed index is taken, and restart_word then equals that response's data. In early-restart mode with c = 2 on a 4-word line, this follows the third beat.
- R6: line_done is a one-cycle pulse in the cycle after the last response is taken. line_valid falls in the cycle after a miss is accepted and is not set again until line_done, when it rises together with it.
- R7: miss_ready is low while a refill runs. A miss_valid raised during a refill starts no refill, neither then nor afterwards.
- R8: busy rises in the cycle after a miss is accepted and stays high up to and including the line_done cycle. It is low in the cycle after line_done.
- R9: Only one memory request is outstanding at a time. A request holds mem_req_valid and its address stable until mem_req_ready. No new request appears until the response for the previous one has been taken.
- R10: The missed index, line address and mode are sampled only when a miss is accepted. Changes to those inputs during a refill do not alter the beat order or the addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid | input | 1 | Miss request from the handler |
| miss_ready | output | 1 | High when a miss can be accepted |
| miss_line_addr | input | LINE_ADDR_W | Line address of the miss |
| miss_word_idx | input | IDX_W | Index of the missed word in the line |
| mode_early | input | 1 | 1 = early-restart order, 0 = critical-word-first order |
| mem_req_valid | output | 1 | Word read request to memory |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | LINE_ADDR_W+IDX_W | Word address of the request |
| mem_rsp_valid | input | 1 | Response word is present |
| mem_rsp_data | input | WORD_W | Response word |
| restart_pulse | output | 1 | One-cycle release of the processor |
| restart_word | output | WORD_W | Requested word, valid with restart_pulse |
| line_done | output | 1 | One-cycle pulse after the last beat |
| line_valid | output | 1 | Line buffer holds a complete line |
| line_data | output | WORDS*WORD_W | Line buffer contents, word i at bits [i*WORD_W +: WORD_W] |
| busy | output | 1 | A refill is in progress |

## Verification
The bench builds the block with WORDS = 4, WORD_W = 32 and LINE_ADDR_W = 12. With a 4-word line, a few refills cover every kind of missed index. Index 0 gives no wrap, index 3 wraps right after the first beat, and index 2 wraps in the middle. In early-restart mode a missed index of 3 makes the restart coincide with line_done. Each memory response is a value derived from its address, so a word stored at the wrong index, or a wrong restart_word, shows up directly. Added request and response latencies exercise the hold rule on the request side. Some refills change the miss inputs while the refill runs.

// File: rtl/refill_pkg.sv
package refill_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } refill_state_e;

endpackage

// File: rtl/refill_fsm.sv
module refill_fsm
    import refill_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    output logic             accept,
    output logic             beat_adv,
    output logic             last_beat,
    output logic [IDX_W-1:0] beat_cnt,
    output logic             mem_req_valid,
    output logic             busy,
    output logic             line_done
);

    localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(WORDS - 1);

    refill_state_e state_q, state_d;

    assign last_beat = (beat_cnt == LAST_BEAT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state and outputs
    always_comb begin
        state_d       = state_q;
        accept        = 1'b0;
        beat_adv      = 1'b0;
        mem_req_valid = 1'b0;
        busy          = 1'b1;
        line_done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (miss_valid) begin
                    accept  = 1'b1;
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    beat_adv = 1'b1;
                    state_d  = last_beat ? ST_FINISH : ST_ISSUE;
                end
            end
            ST_FINISH: begin
                line_done = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        beat_cnt <= '0;
        else if (accept)   beat_cnt <= '0;
        else if (beat_adv) beat_cnt <= last_beat ? '0 : beat_cnt + 1'b1;
    end

endmodule

// File: rtl/beat_order_gen.sv
module beat_order_gen #(
    parameter int WORDS = 4,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic [IDX_W-1:0] start_idx,
    input  logic             early_mode,
    input  logic [IDX_W-1:0] beat_cnt,
    output logic [IDX_W-1:0] word_idx
);

    localparam bit POW2 = ((WORDS & (WORDS - 1)) == 0);

    logic [IDX_W-1:0] base;
    assign base = early_mode ? '0 : start_idx;

    generate
        if (WORDS == 1) begin : g_single
            assign word_idx = '0;
        end else if (POW2) begin : g_pow2
            // wrap by natural truncation
            assign word_idx = base + beat_cnt;
        end else begin : g_generic
            logic [IDX_W:0] sum;
            assign sum      = {1'b0, base} + {1'b0, beat_cnt};
            assign word_idx = (sum >= (IDX_W+1)'(WORDS))
                              ? IDX_W'(sum - (IDX_W+1)'(WORDS))
                              : IDX_W'(sum);
        end
    endgenerate

endmodule

// File: rtl/line_store.sv
module line_store #(
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [WORD_W-1:0]       wr_data,
    output logic [WORDS*WORD_W-1:0] line_data
);

    generate
        for (genvar i = 0; i < WORDS; i++) begin : g_word
            logic [WORD_W-1:0] word_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    word_q <= '0;
                else if (wr_en && (wr_idx == IDX_W'(i)))
                    word_q <= wr_data;
            end
            assign line_data[i*WORD_W +: WORD_W] = word_q;
        end
    endgenerate

endmodule

// File: rtl/line_refill_seq.sv
module line_refill_seq #(
    parameter int WORDS       = 4,
    parameter int WORD_W      = 32,
    parameter int LINE_ADDR_W = 26,
    localparam int IDX_W      = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int ADDR_W     = LINE_ADDR_W + IDX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    miss_valid,
    output logic                    miss_ready,
    input  logic [LINE_ADDR_W-1:0]  miss_line_addr,
    input  logic [IDX_W-1:0]        miss_word_idx,
    input  logic                    mode_early,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [ADDR_W-1:0]       mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [WORD_W-1:0]       mem_rsp_data,
    output logic                    restart_pulse,
    output logic [WORD_W-1:0]       restart_word,
    output logic                    line_done,
    output logic                    line_valid,
    output logic [WORDS*WORD_W-1:0] line_data,
    output logic                    busy
);

    logic             accept, beat_adv, last_beat;
    logic [IDX_W-1:0] beat_cnt, word_idx;

    logic [LINE_ADDR_W-1:0] line_q;
    logic [IDX_W-1:0]       crit_q;
    logic                   early_q;

    refill_fsm #(.WORDS(WORDS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .accept        (accept),
        .beat_adv      (beat_adv),
        .last_beat     (last_beat),
        .beat_cnt      (beat_cnt),
        .mem_req_valid (mem_req_valid),
        .busy          (busy),
        .line_done     (line_done)
    );

    beat_order_gen #(.WORDS(WORDS)) u_order (
        .start_idx  (crit_q),
        .early_mode (early_q),
        .beat_cnt   (beat_cnt),
        .word_idx   (word_idx)
    );

    line_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (beat_adv),
        .wr_idx    (word_idx),
        .wr_data   (mem_rsp_data),
        .line_data (line_data)
    );

    assign miss_ready   = !busy;
    assign mem_req_addr = {line_q, word_idx};

    // miss capture, sampled only on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= '0;
            crit_q  <= '0;
            early_q <= 1'b0;
        end else if (accept) begin
            line_q  <= miss_line_addr;
            crit_q  <= miss_word_idx;
            early_q <= mode_early;
        end
    end

    // restart release and line validity
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            restart_pulse <= 1'b0;
            restart_word  <= '0;
            line_valid    <= 1'b0;
        end else begin
            restart_pulse <= beat_adv && (word_idx == crit_q);
            if (beat_adv && (word_idx == crit_q))
                restart_word <= mem_rsp_data;
            if (accept)
                line_valid <= 1'b0;
            else if (beat_adv && last_beat)
                line_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/line_refill_seq_chk.sv
module line_refill_seq_chk #(
    parameter int ADDR_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic              busy,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              restart_pulse,
    input logic              line_done,
    input logic              line_valid
);

    // R5
    restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |=> !restart_pulse);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);

    // R6
    done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> line_valid);

    // R7
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> (busy && !line_valid && !miss_ready));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !line_done) |=> busy);

    // R8
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !busy);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R9
    req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

endmodule

bind line_refill_seq line_refill_seq_chk #(.ADDR_W(LINE_ADDR_W + IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .miss_ready    (miss_ready),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .restart_pulse (restart_pulse),
    .line_done     (line_done),
    .line_valid    (line_valid)
);

// File: tb/line_refill_seq_tb.sv
`timescale 1ns/1ps
module line_refill_seq_tb;

    localparam int WORDS  = 4;
    localparam int WORD_W = 32;
    localparam int LA_W   = 12;
    localparam int IDX_W  = 2;
    localparam int ADDR_W = LA_W + IDX_W;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    miss_valid = 1'b0;
    logic                    miss_ready;
    logic [LA_W-1:0]         miss_line_addr = '0;
    logic [IDX_W-1:0]        miss_word_idx = '0;
    logic                    mode_early = 1'b0;
    logic                    mem_req_valid;
    logic                    mem_req_ready = 1'b0;
    logic [ADDR_W-1:0]       mem_req_addr;
    logic                    mem_rsp_valid = 1'b0;
    logic [WORD_W-1:0]       mem_rsp_data = '0;
    logic                    restart_pulse;
    logic [WORD_W-1:0]       restart_word;
    logic                    line_done;
    logic                    line_valid;
    logic [WORDS*WORD_W-1:0] line_data;
    logic                    busy;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    line_refill_seq #(.WORDS(WORDS), .WORD_W(WORD_W), .LINE_ADDR_W(LA_W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .miss_valid     (miss_valid),
        .miss_ready     (miss_ready),
        .miss_line_addr (miss_line_addr),
        .miss_word_idx  (miss_word_idx),
        .mode_early     (mode_early),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_addr   (mem_req_addr),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_data   (mem_rsp_data),
        .restart_pulse  (restart_pulse),
        .restart_word   (restart_word),
        .line_done      (line_done),
        .line_valid     (line_valid),
        .line_data      (line_data),
        .busy           (busy)
    );

    function automatic logic [WORD_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return 32'h5A000000 ^ (32'(a) * 32'd40503) ^ 32'(a);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_reset();
        @(negedge clk);
        chk(busy == 1'b0,          "R1", "busy",          64'(busy), 0);
        chk(miss_ready == 1'b1,    "R1", "miss_ready",    64'(miss_ready), 1);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", 64'(mem_req_valid), 0);
        chk(restart_pulse == 1'b0, "R1", "restart_pulse", 64'(restart_pulse), 0);
        chk(line_done == 1'b0,     "R1", "line_done",     64'(line_done), 0);
        chk(line_valid == 1'b0,    "R1", "line_valid",    64'(line_valid), 0);
    endtask

    // one complete refill; intrude drives a competing miss during it
    task automatic run_refill(input logic [LA_W-1:0] line, input int crit,
                              input bit early, input int rdy_dly, input int rsp_lat,
                              input bit intrude);
        string ord_req;
        ord_req = intrude ? "R10" : (early ? "R3" : "R2");
        @(negedge clk);
        miss_valid     = 1'b1;
        miss_line_addr = line;
        miss_word_idx  = IDX_W'(crit);
        mode_early     = early;
        @(negedge clk);
        miss_valid = 1'b0;
        chk(busy == 1'b1,       "R8", "busy after accept",       64'(busy), 1);
        chk(miss_ready == 1'b0, "R7", "miss_ready after accept", 64'(miss_ready), 0);
        chk(line_valid == 1'b0, "R6", "line_valid after accept", 64'(line_valid), 0);
        if (intrude) begin
            miss_valid     = 1'b1;
            miss_line_addr = ~line;
            miss_word_idx  = IDX_W'(crit + 1);
            mode_early     = !early;
        end
        for (int b = 0; b < WORDS; b++) begin
            int exp_idx;
            logic [ADDR_W-1:0] exp_addr;
            exp_idx  = early ? b : (crit + b) % WORDS;
            exp_addr = {line, IDX_W'(exp_idx)};
            chk(mem_req_valid == 1'b1, "R9", "request present", 64'(mem_req_valid), 1);
            chk(mem_req_addr == exp_addr, ord_req, "beat address",
                64'(mem_req_addr), 64'(exp_addr));
            for (int d = 0; d < rdy_dly; d++) begin
                @(negedge clk);
                chk(mem_req_valid && (mem_req_addr == exp_addr), "R9", "request held",
                    64'(mem_req_addr), 64'(exp_addr));
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            chk(mem_req_valid == 1'b0, "R9", "no request while waiting",
                64'(mem_req_valid), 0);
            for (int l = 0; l < rsp_lat; l++) @(negedge clk);
            if (intrude && b == WORDS - 1) miss_valid = 1'b0;
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem_word(exp_addr);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = '0;
            chk(restart_pulse == (exp_idx == crit), "R5", "restart timing",
                64'(restart_pulse), 64'(exp_idx == crit));
            if (exp_idx == crit)
                chk(restart_word == mem_word(exp_addr), "R5", "restart word",
                    64'(restart_word), 64'(mem_word(exp_addr)));
            chk(line_done == (b == WORDS - 1), "R6", "line_done timing",
                64'(line_done), 64'(b == WORDS - 1));
            if (b == WORDS - 1) begin
                chk(line_valid == 1'b1, "R6", "line_valid with done", 64'(line_valid), 1);
                chk(busy == 1'b1, "R8", "busy during done", 64'(busy), 1);
            end else begin
                chk(line_valid == 1'b0, "R6", "line_valid mid refill", 64'(line_valid), 0);
            end
        end
        @(negedge clk);
        chk(busy == 1'b0,          "R8", "busy after done",     64'(busy), 0);
        chk(line_done == 1'b0,     "R6", "done single cycle",   64'(line_done), 0);
        chk(restart_pulse == 1'b0, "R5", "restart single cycle", 64'(restart_pulse), 0);
        chk(miss_ready == 1'b1,    "R7", "ready after done",    64'(miss_ready), 1);
        chk(line_valid == 1'b1,    "R6", "line_valid held",     64'(line_valid), 1);
        for (int i = 0; i < WORDS; i++) begin
            logic [ADDR_W-1:0] a;
            a = {line, IDX_W'(i)};
            chk(line_data[i*WORD_W +: WORD_W] == mem_word(a), "R4", "stored word",
                64'(line_data[i*WORD_W +: WORD_W]), 64'(mem_word(a)));
        end
        if (intrude) begin
            @(negedge clk);
            chk(busy == 1'b0 && mem_req_valid == 1'b0, "R7", "no refill from refused miss",
                64'({busy, mem_req_valid}), 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        check_reset();
        rst_n = 1'b1;
        check_reset();
        run_refill(12'h123, 2, 1'b0, 0, 0, 1'b0);  // order 2,3,0,1
        run_refill(12'h123, 2, 1'b1, 0, 0, 1'b0);  // order 0,1,2,3; restart on third beat
        run_refill(12'h0F0, 0, 1'b0, 1, 2, 1'b0);  // no wrap
        run_refill(12'hABC, 3, 1'b0, 0, 1, 1'b0);  // wrap after first beat
        run_refill(12'h555, 3, 1'b1, 2, 0, 1'b0);  // restart with line_done
        run_refill(12'h321, 1, 1'b0, 1, 1, 1'b1);  // competing miss, inputs change
        run_refill(12'hFFF, 0, 1'b1, 0, 3, 1'b1);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule